// File: doc/BRIEF.md
# Snoop Intervention Controller

This block forms the snoop response for one cache's line-state array. Each request carries the current state of one line and an operation. The operation is either a snoop read from another bus agent or a local fill of a line that this cache has just fetched. In return the block decides three things: whether the cache supplies the data directly (intervention), whether it must retry the requester and push the line out with a write-with-kill, or whether it simply answers. It also gates the shared-indication lines in both directions and reports the next state of the line.

The coherency protocol is chosen at run time. A shared-enable bit selects 3-state MEI or 4-state MESI. Setting a level's intervention field to full eligibility (code 111) turns on 5-state MERSI, in which a Recent line can also supply data. A bus-mode pin is captured while reset is held. Intervention and the second shared line exist only in the extended bus mode. A legality check flags illegal field codes, and it also flags a level-2 setting that is more permissive than the level-1 setting.

A response is registered and appears exactly one cycle after the request. The configuration inputs are copied into a shadow register only in cycles with no request. As a result, a change that lands together with a snoop does not affect that snoop.

Top module: `snoop_ivc`

## Requirements
- R1: While reset is high and in the cycle after it, rsp_valid, rsp_intv, rsp_retry, rsp_push and cfg_err are 0 and rsp_shd_out is 00.
- R2: rsp_valid is 1 exactly in the cycle after a cycle with req_valid=1, and 0 after a cycle with req_valid=0.
- R3: mode_ext takes the value of mode_pin during reset. Changes on mode_pin after reset leave it unchanged.
- R4: cfg_err becomes 1 when either intervention field (cfg_l1_iv or cfg_l2_iv) holds 001, 010, 011 or 101.
- R5: With legal codes ranked 000 < 100 < 110 < 111, cfg_err is 1 exactly when the rank of cfg_l2_iv exceeds the rank of cfg_l1_iv.
- R6: In legacy mode (mode_ext=0) there is never intervention. A snoop read hit on a Modified line gives rsp_retry=1 and rsp_push=1 with next state Invalid. The same holds in any mode when the selected field has bit 2 clear.
- R7: Line state codes are I=000, S=001, E=010, M=011, R=100. Field 100 in extended mode: a snoop read of M intervenes, and a snoop read of E does not.
- R8: Field 110 in extended mode: a snoop read of E intervenes. With shared enable set and a field other than 111, an intervened line moves to S. With shared enable clear, it moves to I.
- R9: Field 111 with shared enable set gives MERSI. An intervened M or E line moves to R. A snoop read of R intervenes and moves the line to S.
- R10: rsp_shd_out[0] is driven when the line is kept (next state not I) and either enable bit is set. rsp_shd_out[1] is driven only under those conditions and also in extended mode.
- R11: rsp_shd_seen = (shd_in[0] or (shd_in[1] and extended mode)), counted only when either enable bit is set. A local fill (req_fill=1) moves the line to E when nothing is seen or shared enable is clear. Otherwise it moves the line to R under MERSI and to S otherwise.
- R12: A configuration change applied in the same cycle as req_valid=1 does not affect that snoop.
- R13: While the shadowed configuration is illegal, intervention is disabled and the block behaves as with field 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pin | input | 1 | Bus mode strap, captured during reset (1 = extended) |
| cfg_shd_en | input | 1 | Shared-state enable (0 MEI, 1 MESI/MERSI) |
| cfg_shd3_en | input | 1 | Shared line enable while cfg_shd_en is 0 |
| cfg_l1_iv | input | 3 | Level-1 intervention field |
| cfg_l2_iv | input | 3 | Level-2 intervention field |
| req_valid | input | 1 | Request strobe |
| req_fill | input | 1 | 1 = local fill, 0 = snoop read |
| req_lvl | input | 1 | Field select: 0 level-1, 1 level-2 |
| req_state | input | 3 | Current line state |
| shd_in | input | 2 | Shared lines sampled from the bus |
| rsp_valid | output | 1 | Response strobe |
| rsp_intv | output | 1 | Supply data by intervention |
| rsp_retry | output | 1 | Retry the requester |
| rsp_push | output | 1 | Push line with write-with-kill |
| rsp_shd_out | output | 2 | Shared lines driven to the bus |
| rsp_shd_seen | output | 1 | Gated shared sample |
| rsp_next | output | 3 | Next line state |
| cfg_err | output | 1 | Illegal configuration |
| mode_ext | output | 1 | Captured bus mode |

## Verification
The assertions assume that req_state carries one of the five defined codes. They also assume that mode_pin is only meaningful during reset, so a later toggle on it is legitimate stimulus and not a violation. The bench drives only defined state codes. It changes configuration while no request is active, except in the one scenario that targets R12, and it then waits until the shadow copy and cfg_err have settled before the next snoop.

// File: rtl/snoop_ivc_pkg.sv
package snoop_ivc_pkg;
  localparam int ST_W  = 3;
  localparam int IV_W  = 3;
  localparam int SHD_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_I = 3'b000,
    ST_S = 3'b001,
    ST_E = 3'b010,
    ST_M = 3'b011,
    ST_R = 3'b100
  } line_st_t;

  localparam logic [IV_W-1:0] IV_OFF  = 3'b000;
  localparam logic [IV_W-1:0] IV_M    = 3'b100;
  localparam logic [IV_W-1:0] IV_ME   = 3'b110;
  localparam logic [IV_W-1:0] IV_MER  = 3'b111;

  typedef struct packed {
    logic            shd_en;
    logic            shd3_en;
    logic [IV_W-1:0] l1_iv;
    logic [IV_W-1:0] l2_iv;
  } cfg_t;

  function automatic logic iv_legal(input logic [IV_W-1:0] c);
    return (c == IV_OFF) || (c == IV_M) || (c == IV_ME) || (c == IV_MER);
  endfunction

  function automatic logic [1:0] iv_rank(input logic [IV_W-1:0] c);
    case (c)
      IV_M:    return 2'd1;
      IV_ME:   return 2'd2;
      IV_MER:  return 2'd3;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/snoop_ivc_cfg.sv
module snoop_ivc_cfg
  import snoop_ivc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  cfg_t cfg_in,
  output cfg_t cfg_q,
  output logic illegal
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (!hold) begin
      cfg_q <= cfg_in;
    end
  end

  logic bad_code;
  logic bad_order;
  always_comb begin
    bad_code  = !iv_legal(cfg_q.l1_iv) || !iv_legal(cfg_q.l2_iv);
    bad_order = iv_rank(cfg_q.l2_iv) > iv_rank(cfg_q.l1_iv);
    illegal   = bad_code || bad_order;
  end
endmodule

// File: rtl/snoop_ivc_shared.sv
module snoop_ivc_shared
  import snoop_ivc_pkg::*;
(
  input  logic             ext,
  input  logic             shd_en,
  input  logic             shd3_en,
  input  logic [SHD_W-1:0] shd_in,
  input  logic             keep,
  output logic             seen,
  output logic [SHD_W-1:0] drive
);
  logic [SHD_W-1:0] line_en;
  always_comb begin
    line_en[0] = shd_en || shd3_en;
    line_en[1] = (shd_en || shd3_en) && ext;
    seen  = |(shd_in & line_en);
    drive = keep ? line_en : '0;
  end
endmodule

// File: rtl/snoop_ivc_decide.sv
module snoop_ivc_decide
  import snoop_ivc_pkg::*;
(
  input  logic            fill,
  input  logic [ST_W-1:0] state,
  input  logic [IV_W-1:0] iv_eff,
  input  logic            shd_en,
  input  logic            mersi,
  input  logic            seen,
  output logic            intv,
  output logic            retry,
  output logic            push,
  output logic [ST_W-1:0] next
);
  logic [ST_W-1:0] after_supply;
  always_comb begin
    after_supply = mersi ? ST_R : (shd_en ? ST_S : ST_I);
    intv  = 1'b0;
    retry = 1'b0;
    push  = 1'b0;
    next  = ST_I;
    if (fill) begin
      if (shd_en && seen) next = mersi ? ST_R : ST_S;
      else                next = ST_E;
    end else begin
      case (state)
        ST_M: begin
          if (iv_eff[2]) begin
            intv = 1'b1;
            next = after_supply;
          end else begin
            retry = 1'b1;
            push  = 1'b1;
            next  = ST_I;
          end
        end
        ST_E: begin
          if (iv_eff[1]) begin
            intv = 1'b1;
            next = after_supply;
          end else begin
            next = shd_en ? ST_S : ST_I;
          end
        end
        ST_R: begin
          intv = iv_eff[0] && mersi;
          next = ST_S;
        end
        ST_S:    next = ST_S;
        default: next = ST_I;
      endcase
    end
  end
endmodule

// File: rtl/snoop_ivc.sv
module snoop_ivc
  import snoop_ivc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_pin,
  input  logic             cfg_shd_en,
  input  logic             cfg_shd3_en,
  input  logic [IV_W-1:0]  cfg_l1_iv,
  input  logic [IV_W-1:0]  cfg_l2_iv,
  input  logic             req_valid,
  input  logic             req_fill,
  input  logic             req_lvl,
  input  logic [ST_W-1:0]  req_state,
  input  logic [SHD_W-1:0] shd_in,
  output logic             rsp_valid,
  output logic             rsp_intv,
  output logic             rsp_retry,
  output logic             rsp_push,
  output logic [SHD_W-1:0] rsp_shd_out,
  output logic             rsp_shd_seen,
  output logic [ST_W-1:0]  rsp_next,
  output logic             cfg_err,
  output logic             mode_ext
);
  cfg_t cfg_in, cfg_q;
  logic illegal;

  always_comb begin
    cfg_in.shd_en  = cfg_shd_en;
    cfg_in.shd3_en = cfg_shd3_en;
    cfg_in.l1_iv   = cfg_l1_iv;
    cfg_in.l2_iv   = cfg_l2_iv;
  end

  snoop_ivc_cfg u_cfg (
    .clk(clk), .rst(rst), .hold(req_valid),
    .cfg_in(cfg_in), .cfg_q(cfg_q), .illegal(illegal)
  );

  always_ff @(posedge clk) begin
    if (rst) mode_ext <= mode_pin;
  end

  logic [IV_W-1:0] iv_sel, iv_eff;
  logic            mersi, keep, seen;
  logic            d_intv, d_retry, d_push;
  logic [ST_W-1:0] d_next;
  logic [SHD_W-1:0] d_drive;

  always_comb begin
    iv_sel = req_lvl ? cfg_q.l2_iv : cfg_q.l1_iv;
    iv_eff = (mode_ext && !illegal) ? iv_sel : IV_OFF;
    mersi  = cfg_q.shd_en && (iv_eff == IV_MER);
    keep   = !req_fill && (d_next != ST_I);
  end

  snoop_ivc_shared u_shd (
    .ext(mode_ext), .shd_en(cfg_q.shd_en), .shd3_en(cfg_q.shd3_en),
    .shd_in(shd_in), .keep(keep), .seen(seen), .drive(d_drive)
  );

  snoop_ivc_decide u_dec (
    .fill(req_fill), .state(req_state), .iv_eff(iv_eff),
    .shd_en(cfg_q.shd_en), .mersi(mersi), .seen(seen),
    .intv(d_intv), .retry(d_retry), .push(d_push), .next(d_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_intv     <= 1'b0;
      rsp_retry    <= 1'b0;
      rsp_push     <= 1'b0;
      rsp_shd_out  <= '0;
      rsp_shd_seen <= 1'b0;
      rsp_next     <= ST_I;
      cfg_err      <= 1'b0;
    end else begin
      cfg_err   <= illegal;
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_intv     <= d_intv;
        rsp_retry    <= d_retry;
        rsp_push     <= d_push;
        rsp_shd_out  <= d_drive;
        rsp_shd_seen <= seen;
        rsp_next     <= d_next;
      end else begin
        rsp_intv    <= 1'b0;
        rsp_retry   <= 1'b0;
        rsp_push    <= 1'b0;
        rsp_shd_out <= '0;
      end
    end
  end
endmodule

// File: rtl/snoop_ivc_chk.sv
module snoop_ivc_chk
  import snoop_ivc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic             rsp_intv,
  input logic             rsp_retry,
  input logic             rsp_push,
  input logic [SHD_W-1:0] rsp_shd_out,
  input logic [ST_W-1:0]  rsp_next,
  input logic             mode_ext
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R2
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    $stable(mode_ext)); // R3
  AST_LEGACY_NO_INTV: assert property (@(posedge clk) disable iff (rst)
    !mode_ext |-> !rsp_intv); // R6
  AST_PUSH_NEEDS_RETRY: assert property (@(posedge clk) disable iff (rst)
    rsp_push |-> (rsp_retry && !rsp_intv && rsp_next == ST_I)); // R6
  AST_INTV_GIVES_UP_OWNERSHIP: assert property (@(posedge clk) disable iff (rst)
    rsp_intv |-> (rsp_next != ST_M && rsp_next != ST_E)); // R9
  AST_LINE1_EXT_ONLY: assert property (@(posedge clk) disable iff (rst)
    !mode_ext |-> !rsp_shd_out[1]); // R10
  AST_NO_SHD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_shd_out == '0)); // R10
endmodule

bind snoop_ivc snoop_ivc_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_intv(rsp_intv), .rsp_retry(rsp_retry), .rsp_push(rsp_push),
  .rsp_shd_out(rsp_shd_out), .rsp_next(rsp_next), .mode_ext(mode_ext)
);

// File: tb/test_snoop_ivc.sv
`timescale 1ns/1ps
module test_snoop_ivc;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_pin = 1'b0;
  logic cfg_shd_en = 1'b0, cfg_shd3_en = 1'b0;
  logic [2:0] cfg_l1_iv = 3'b000, cfg_l2_iv = 3'b000;
  logic req_valid = 1'b0, req_fill = 1'b0, req_lvl = 1'b0;
  logic [2:0] req_state = 3'b000;
  logic [1:0] shd_in = 2'b00;
  logic rsp_valid, rsp_intv, rsp_retry, rsp_push, rsp_shd_seen, cfg_err, mode_ext;
  logic [1:0] rsp_shd_out;
  logic [2:0] rsp_next;

  localparam logic [2:0] I = 3'b000, S = 3'b001, E = 3'b010, M = 3'b011, R = 3'b100;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  snoop_ivc i_snoop_ivc (.*);

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_reset(input logic pin);
    @(negedge clk);
    rst = 1'b1; mode_pin = pin;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic se, input logic s3, input logic [2:0] a, input logic [2:0] b);
    cfg_shd_en = se; cfg_shd3_en = s3; cfg_l1_iv = a; cfg_l2_iv = b;
    repeat (3) @(negedge clk);
  endtask

  task automatic req(input logic fill, input logic lvl, input logic [2:0] st, input logic [1:0] sh);
    req_valid = 1'b1; req_fill = fill; req_lvl = lvl; req_state = st; shd_in = sh;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rsp_valid", rsp_valid, 1);
  endtask

  task automatic t_reset;
    rst = 1'b1; mode_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", rsp_valid, 0);
    chk("R1 cfg_err in reset", cfg_err, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 intv", rsp_intv, 0);
    chk("R1 retry", rsp_retry, 0);
    chk("R1 shd_out", rsp_shd_out, 0);
    chk("R3 mode legacy", mode_ext, 0);
  endtask

  task automatic t_legacy;
    set_cfg(1, 0, 3'b111, 3'b111);
    req(0, 0, M, 2'b00);
    chk("R6 retry", rsp_retry, 1);
    chk("R6 push", rsp_push, 1);
    chk("R6 intv", rsp_intv, 0);
    chk("R6 next", rsp_next, I);
    @(negedge clk);
    chk("R2 idle", rsp_valid, 0);
    req(0, 0, E, 2'b00);
    chk("R6 E no intv", rsp_intv, 0);
    chk("R8 E next S", rsp_next, S);
    chk("R10 legacy shd_out", rsp_shd_out, 2'b01);
    req(1, 0, I, 2'b10);
    chk("R11 line1 ignored legacy", rsp_shd_seen, 0);
    chk("R11 fill E", rsp_next, E);
    req(1, 0, I, 2'b01);
    chk("R11 seen", rsp_shd_seen, 1);
    chk("R11 fill S", rsp_next, S);
    mode_pin = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 pin after reset", mode_ext, 0);
  endtask

  task automatic t_field100;
    do_reset(1);
    chk("R3 mode ext", mode_ext, 1);
    set_cfg(1, 0, 3'b100, 3'b000);
    chk("R5 100/000 legal", cfg_err, 0);
    req(0, 0, M, 2'b00);
    chk("R7 M intv", rsp_intv, 1);
    chk("R7 M no retry", rsp_retry, 0);
    chk("R8 M next S", rsp_next, S);
    chk("R10 ext shd_out", rsp_shd_out, 2'b11);
    req(0, 0, E, 2'b00);
    chk("R7 E no intv", rsp_intv, 0);
    chk("R7 E next S", rsp_next, S);
    req(0, 1, M, 2'b00);
    chk("R6 L2 off retry", rsp_retry, 1);
    chk("R6 L2 off push", rsp_push, 1);
  endtask

  task automatic t_field110;
    set_cfg(1, 0, 3'b110, 3'b100);
    chk("R5 110/100 legal", cfg_err, 0);
    req(0, 0, E, 2'b00);
    chk("R8 E intv", rsp_intv, 1);
    chk("R8 E next S", rsp_next, S);
    req(0, 1, E, 2'b00);
    chk("R7 L2 E no intv", rsp_intv, 0);
    req(0, 0, R, 2'b00);
    chk("R9 R no intv non-mersi", rsp_intv, 0);
  endtask

  task automatic t_mersi;
    set_cfg(1, 0, 3'b111, 3'b111);
    chk("R5 111/111 legal", cfg_err, 0);
    req(0, 0, M, 2'b00);
    chk("R9 M intv", rsp_intv, 1);
    chk("R9 M next R", rsp_next, R);
    req(0, 1, E, 2'b00);
    chk("R9 E next R", rsp_next, R);
    req(0, 0, R, 2'b00);
    chk("R9 R intv", rsp_intv, 1);
    chk("R9 R next S", rsp_next, S);
    req(1, 0, I, 2'b10);
    chk("R11 line1 ext seen", rsp_shd_seen, 1);
    chk("R11 fill R", rsp_next, R);
    req(0, 0, I, 2'b00);
    chk("R10 I no shd", rsp_shd_out, 0);
    chk("R9 I no intv", rsp_intv, 0);
  endtask

  task automatic t_illegal;
    set_cfg(1, 0, 3'b101, 3'b000);
    chk("R4 101 err", cfg_err, 1);
    req(0, 0, M, 2'b00);
    chk("R13 err retry", rsp_retry, 1);
    chk("R13 err no intv", rsp_intv, 0);
    set_cfg(1, 0, 3'b111, 3'b011);
    chk("R4 l2 011 err", cfg_err, 1);
    set_cfg(1, 0, 3'b100, 3'b110);
    chk("R5 order err", cfg_err, 1);
    req(0, 0, M, 2'b00);
    chk("R13 order err retry", rsp_retry, 1);
    set_cfg(1, 0, 3'b111, 3'b110);
    chk("R5 111/110 legal", cfg_err, 0);
  endtask

  task automatic t_shared_gate;
    set_cfg(0, 0, 3'b100, 3'b000);
    req(1, 0, I, 2'b11);
    chk("R11 off not seen", rsp_shd_seen, 0);
    chk("R11 mei fill E", rsp_next, E);
    req(0, 0, S, 2'b00);
    chk("R10 off no drive", rsp_shd_out, 0);
    req(0, 0, M, 2'b00);
    chk("R8 mei intv", rsp_intv, 1);
    chk("R8 mei next I", rsp_next, I);
    set_cfg(0, 1, 3'b000, 3'b000);
    req(1, 0, I, 2'b10);
    chk("R11 shd3 line1 seen", rsp_shd_seen, 1);
    chk("R11 mei fill stays E", rsp_next, E);
    req(0, 0, S, 2'b00);
    chk("R10 shd3 drive", rsp_shd_out, 2'b11);
  endtask

  task automatic t_cfg_ignore;
    set_cfg(1, 0, 3'b100, 3'b000);
    cfg_l1_iv = 3'b000;
    req(0, 0, M, 2'b00);
    chk("R12 old cfg used", rsp_intv, 1);
    repeat (3) @(negedge clk);
    req(0, 0, M, 2'b00);
    chk("R12 new cfg after", rsp_retry, 1);
  endtask

  initial begin
    t_reset();
    t_legacy();
    t_field100();
    t_field110();
    t_mersi();
    t_illegal();
    t_shared_gate();
    t_cfg_ignore();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got 0 expected 1");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule